// File: doc/BRIEF.md
# Byte/Word Configurable Memory Bus Interface

This block connects an external parallel memory bus, driven by an outside master with active-low chip enable, output enable and write enable strobes, to a 16-bit-wide internal storage array and to a command port. All bus inputs pass through a two-stage synchronizer into the core clock domain. A qualified read cycle issues a read to the synchronous storage array, which returns data one clock later, and then drives the data pins through per-bit tri-state enables. A qualified write cycle is held until it ends and then yields a single-cycle command strobe.

A mode input selects the bus width. In word mode all sixteen data pins carry data. In byte mode only the low eight pins carry data, the upper pins are released, and the top data pin becomes an extra low-order address input that picks one half of the stored word. Write data is always cut down to its low byte before it reaches the command port.

The storage array sits outside this block and is reached through a read-enable, address and read-data port with a fixed read latency of one clock. Command interpretation is left to whatever consumes the command strobe.

Top module: `bwmem_bus_if`

## Requirements
- R1: With `bus_word_mode` high (word mode), a read cycle drives all 16 `dq_oe` bits high and `dq_out` equals the stored word at `bus_addr`.
- R2: With `bus_word_mode` low (byte mode), `dq_oe[15:8]` stays 0 for every bus cycle, and a read drives only `dq_oe[7:0]` high, with `dq_out[15:8]` at 0.
- R3: In byte mode, `dq_in[15]` is a byte select: 0 puts bits 7:0 of the stored word on `dq_out[7:0]`, 1 puts bits 15:8 there, and its value appears as bit 0 of `cmd_addr` on a write.
- R4: In word mode, `dq_in[15]` is ordinary data: it has no effect on read output, and `cmd_addr` bit 0 is 0 on every write.
- R5: While `bus_ce_n` is high, no read drives the pins and no write produces a command strobe, whatever the other bus inputs do.
- R6: `dq_oe` is nonzero only for a read cycle (`bus_ce_n` low, `bus_oe_n` low, `bus_we_n` high); in every other case, including after reset, all of `dq_oe` is 0.
- R7: A write passes only `dq_in[7:0]` to `cmd_data`; data bits 15:8 are discarded.
- R8: When `bus_oe_n` and `bus_we_n` are both low with chip enable asserted, the cycle is a write: the outputs stay disabled and a command strobe follows its end.
- R9: A write ends when `bus_we_n` or `bus_ce_n` rises, whichever comes first; each write then produces exactly one `cmd_valid` pulse one clock long, with `cmd_addr` = {`bus_addr`, select bit} and `cmd_data` taken from the last synchronized cycle of the write.
- R10: Read output follows the bus inputs after four clock edges: two synchronizer stages, the storage array read, and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_word_mode | input | 1 | 1 selects word mode, 0 selects byte mode |
| bus_addr | input | AW (8) | Word address from the bus |
| dq_in | input | DW (16) | Data pins as seen from the bus; bit 15 is the byte select in byte mode |
| dq_out | output | DW (16) | Data driven toward the pins |
| dq_oe | output | DW (16) | Per-pin output enable, 1 drives the pin |
| mem_rd_en | output | 1 | Read request to the storage array |
| mem_rd_addr | output | AW (8) | Word address to the storage array |
| mem_rd_data | input | DW (16) | Storage array read data, valid one clock after the request |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | AW+1 (9) | Command address: word address above, byte select in bit 0 |
| cmd_data | output | 8 | Low data byte of the write |

## Verification
The assertions assume the bus master keeps address, data and mode steady during a bus cycle and holds each strobe level for at least two core clocks, so that every level reaches the second synchronizer stage. They also assume the storage array answers every read request in exactly one clock. The stimulus changes inputs only on falling clock edges, holds every bus cycle for several clocks, and models the storage array as a registered lookup computed from the address, so both assumptions hold throughout.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;

  typedef enum logic {
    BUS_BYTE = 1'b0,
    BUS_WORD = 1'b1
  } bus_width_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic word_mode;
  } bus_ctl_t;

  localparam int unsigned CTL_W = $bits(bus_ctl_t);

  localparam bus_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, word_mode: 1'b0};

endpackage

// File: rtl/bwmem_rst_sync.sv
module bwmem_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bwmem_sync.sv
module bwmem_sync #(
  parameter int unsigned     W       = 8,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] r;
    logic [W-1:0] r_nxt;
    if (i == 0) begin : g_head
      always_comb r_nxt = d;
    end else begin : g_tail
      always_comb r_nxt = g_stg[i-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= r_nxt;
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/bwmem_read_path.sv
module bwmem_read_path #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          word_mode,
  input  logic          byte_sel,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe
);

  localparam int unsigned HALF = DW / 2;

  logic          a_vld_q,  a_vld_nxt;
  logic          a_word_q, a_word_nxt;
  logic          a_sel_q,  a_sel_nxt;
  logic [DW-1:0] out_q,    out_nxt;
  logic [DW-1:0] oe_q,     oe_nxt;

  always_comb begin
    a_vld_nxt  = rd_req;
    a_word_nxt = word_mode;
    a_sel_nxt  = byte_sel;
  end

  always_comb begin
    out_nxt = '0;
    oe_nxt  = '0;
    if (a_vld_q) begin
      if (a_word_q) begin
        out_nxt = mem_rd_data;
        oe_nxt  = '1;
      end else begin
        out_nxt[HALF-1:0] = a_sel_q ? mem_rd_data[DW-1:HALF] : mem_rd_data[HALF-1:0];
        oe_nxt[HALF-1:0]  = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q  <= 1'b0;
      a_word_q <= 1'b0;
      a_sel_q  <= 1'b0;
      out_q    <= '0;
      oe_q     <= '0;
    end else begin
      a_vld_q  <= a_vld_nxt;
      a_word_q <= a_word_nxt;
      a_sel_q  <= a_sel_nxt;
      out_q    <= out_nxt;
      oe_q     <= oe_nxt;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;

endmodule

// File: rtl/bwmem_write_capture.sv
module bwmem_write_capture #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic [AW-1:0] addr,
  input  logic          word_mode,
  input  logic          byte_sel,
  input  logic [CW-1:0] data_lo,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [CW-1:0] cmd_data
);

  logic          wr_prev_q, wr_prev_nxt;
  logic [AW:0]   hold_addr_q, hold_addr_nxt;
  logic [CW-1:0] hold_data_q, hold_data_nxt;
  logic          hold_en;
  logic          strobe;
  logic          vld_q;
  logic [AW:0]   caddr_q;
  logic [CW-1:0] cdata_q;

  always_comb begin
    wr_prev_nxt   = wr_act;
    hold_en       = wr_act;
    hold_addr_nxt = {addr, (word_mode ? 1'b0 : byte_sel)};
    hold_data_nxt = data_lo;
    strobe        = wr_prev_q & ~wr_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q   <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else begin
      wr_prev_q <= wr_prev_nxt;
      if (hold_en) begin
        hold_addr_q <= hold_addr_nxt;
        hold_data_q <= hold_data_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      vld_q <= strobe;
      if (strobe) begin
        caddr_q <= hold_addr_q;
        cdata_q <= hold_data_q;
      end
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_addr  = caddr_q;
  assign cmd_data  = cdata_q;

endmodule

// File: rtl/bwmem_bus_if.sv
module bwmem_bus_if
  import bwmem_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_n,
  input  logic          bus_word_mode,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [7:0]    cmd_data
);

  localparam int unsigned CMD_W = 8;
  localparam int unsigned SMP_W = CTL_W + AW + DW;
  localparam logic [SMP_W-1:0] SMP_RST = {CTL_IDLE, {(AW + DW){1'b0}}};

  logic             rst_core_n;
  logic [SMP_W-1:0] smp_d, smp_q;
  bus_ctl_t         ctl_s;
  logic [AW-1:0]    addr_s;
  logic [DW-1:0]    data_s;
  logic             rd_req;
  logic             wr_act;
  logic             byte_sel;

  bwmem_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign smp_d = {bus_ce_n, bus_oe_n, bus_we_n, bus_word_mode, bus_addr, dq_in};

  bwmem_sync #(.W(SMP_W), .STAGES(SYNC_STGS), .RST_VAL(SMP_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (smp_d),
    .q     (smp_q)
  );

  always_comb begin
    ctl_s    = bus_ctl_t'(smp_q[SMP_W-1 -: CTL_W]);
    addr_s   = smp_q[DW +: AW];
    data_s   = smp_q[DW-1:0];
    wr_act   = ~ctl_s.ce_n & ~ctl_s.we_n;
    rd_req   = ~ctl_s.ce_n & ~ctl_s.oe_n & ctl_s.we_n;
    byte_sel = (ctl_s.word_mode == BUS_BYTE) ? data_s[DW-1] : 1'b0;
  end

  assign mem_rd_en   = rd_req;
  assign mem_rd_addr = addr_s;

  bwmem_read_path #(.DW(DW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .rd_req      (rd_req),
    .word_mode   (ctl_s.word_mode),
    .byte_sel    (byte_sel),
    .mem_rd_data (mem_rd_data),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe)
  );

  bwmem_write_capture #(.AW(AW), .CW(CMD_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_act    (wr_act),
    .addr      (addr_s),
    .word_mode (ctl_s.word_mode),
    .byte_sel  (byte_sel),
    .data_lo   (data_s[CMD_W-1:0]),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

endmodule

// File: rtl/bwmem_bus_chk.sv
module bwmem_bus_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_act,
  input logic          ce_n_s,
  input logic          word_s,
  input logic [DW-1:0] dq_oe,
  input logic          cmd_valid
);

  localparam int unsigned HALF = DW / 2;
  localparam logic [DW-1:0] OE_LOW = {{HALF{1'b0}}, {HALF{1'b1}}};

  // R2: the enable vector is all off, the low half only, or all on
  p_oe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == OE_LOW) || (dq_oe == '1));

  // R2: upper pins driven only for a word-mode cycle two clocks earlier
  p_upper_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[DW-1:HALF] != '0) |-> $past(word_s, 2));

  // R8: an active write keeps every pin released
  p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_act, 2) |-> (dq_oe == '0));

  // R5: a strobe only follows a cycle with chip enable asserted
  p_ce_gates_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(ce_n_s, 2));

  // R9: the command strobe lasts one clock
  p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

endmodule

bind bwmem_bus_if bwmem_bus_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .wr_act    (wr_act),
  .ce_n_s    (ctl_s.ce_n),
  .word_s    (ctl_s.word_mode),
  .dq_oe     (dq_oe),
  .cmd_valid (cmd_valid)
);

// File: tb/bwmem_bus_if_test.sv
`timescale 1ns/1ps
module bwmem_bus_if_test;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 10;

  logic          clk;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, word_mode;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out, dq_oe;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic          cmd_valid;
  logic [AW:0]   cmd_addr;
  logic [7:0]    cmd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  logic [AW:0] last_addr;
  logic [7:0]  last_data;

  bwmem_bus_if #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_word_mode(word_mode), .bus_addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {a ^ 8'h5A, a + 8'h11};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  always @(posedge clk) begin
    if (cmd_valid) begin
      pulses    = pulses + 1;
      last_addr = cmd_addr;
      last_data = cmd_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // fields: ce_n oe_n we_n word sel addr[7:0] exp_oe[15:0]
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h12, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h34, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h56, 16'h00FF},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h56, 16'h00FF},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h12, 16'h0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h12, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h40, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 16'h00FF},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h07, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA0, 16'hFFFF}
  };
  localparam string VTAG [NV] = '{"R1", "R4", "R3", "R3", "R5", "R6", "R8", "R2", "R6", "R10"};

  task automatic do_write(input logic ce_v, input logic wm, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic end_by_ce);
    @(negedge clk);
    word_mode = wm; addr = a; dq_in = d;
    ce_n = ce_v; oe_n = 1'b1; we_n = 1'b0;
    wait_cyc(4);
    if (end_by_ce) ce_n = 1'b1;
    else           we_n = 1'b1;
    wait_cyc(6);
    idle();
    wait_cyc(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int p0;
    logic [DW-1:0] w;
    logic [DW-1:0] exp_out;
    rst_n = 1'b0;
    idle();
    word_mode = 1'b1; addr = '0; dq_in = '0;
    wait_cyc(3);
    check("R6 reset dq_oe", 32'(dq_oe), 32'h0);
    check("R9 reset cmd_valid", 32'(cmd_valid), 32'h0);
    rst_n = 1'b1;
    wait_cyc(5);

    for (int i = 0; i < NV; i++) begin
      ce_n = VEC[i][28]; oe_n = VEC[i][27]; we_n = VEC[i][26];
      word_mode = VEC[i][25]; addr = VEC[i][23:16];
      dq_in = {VEC[i][24], 15'h2A5C};
      wait_cyc(6);
      check(VTAG[i], 32'(dq_oe), 32'(VEC[i][15:0]));
      w = memf(VEC[i][23:16]);
      if (VEC[i][15:0] == 16'hFFFF) exp_out = w;
      else if (VEC[i][15:0] == 16'h00FF) exp_out = {8'h00, (VEC[i][24] ? w[15:8] : w[7:0])};
      else exp_out = dq_out;
      check({VTAG[i], " data"}, 32'(dq_out), 32'(exp_out));
    end
    idle();
    wait_cyc(6);

    // R8: the overlapped vector was a write and gave one strobe
    check("R8 strobe from overlap", 32'(pulses), 32'd1);
    check("R8 overlap addr", 32'(last_addr), 32'({8'h40, 1'b0}));

    p0 = pulses;
    do_write(1'b0, 1'b1, 8'h3C, 16'hBEEF, 1'b0);
    check("R9 word write count", 32'(pulses - p0), 32'd1);
    check("R4 word write addr", 32'(last_addr), 32'({8'h3C, 1'b0}));
    check("R7 word write data", 32'(last_data), 32'h00EF);

    p0 = pulses;
    do_write(1'b0, 1'b0, 8'h21, 16'hD577, 1'b0);
    check("R3 byte write count", 32'(pulses - p0), 32'd1);
    check("R3 byte write addr", 32'(last_addr), 32'({8'h21, 1'b1}));
    check("R7 byte write data", 32'(last_data), 32'h0077);
    check("R2 byte write upper float", 32'(dq_oe), 32'h0);

    p0 = pulses;
    do_write(1'b0, 1'b0, 8'h22, 16'h0031, 1'b0);
    check("R3 byte write low sel", 32'(last_addr), 32'({8'h22, 1'b0}));

    p0 = pulses;
    do_write(1'b1, 1'b1, 8'h55, 16'h1234, 1'b0);
    check("R5 no strobe with ce high", 32'(pulses - p0), 32'd0);
    check("R5 no drive with ce high", 32'(dq_oe), 32'h0);

    p0 = pulses;
    do_write(1'b0, 1'b1, 8'h99, 16'h00C3, 1'b1);
    check("R9 ce ends write count", 32'(pulses - p0), 32'd1);
    check("R9 ce ends write addr", 32'(last_addr), 32'({8'h99, 1'b0}));
    check("R9 ce ends write data", 32'(last_data), 32'h00C3);

    // R10: exact latency of a word read, four edges after the change
    @(negedge clk);
    word_mode = 1'b1; addr = 8'h0F; dq_in = '0;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wait_cyc(3);
    check("R10 not yet driven after 3 edges", 32'(dq_oe), 32'h0);
    wait_cyc(1);
    check("R10 driven after 4 edges", 32'(dq_oe), 32'hFFFF);
    check("R1 latency data", 32'(dq_out), 32'(memf(8'h0F)));
    idle();
    wait_cyc(6);
    check("R6 released after read", 32'(dq_oe), 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule